// File: doc/BRIEF.md
# Receive Destination Address Filter

The filter decides whether an incoming frame is kept, based only on its 48-bit destination address. Octets arrive one per strobe in wire order, and the first octet is flagged by a start marker. After the sixth octet is captured, the filter raises a one-cycle result that carries an accept flag and a code naming the reason for the decision.

Four tests run in parallel, and a fixed priority picks the winner. The first is an exact compare against one programmed station address. The second recognises the all-ones broadcast address. The third looks up a 64-entry multicast hash table, which applies only to group addresses and only when enabled. The hash index is a 6-bit XOR fold of the assembled address. The fourth is a copy-all (promiscuous) mode that keeps every frame. Configuration inputs are expected to stay stable while an address is being evaluated.

Top module: `dest_addr_filter`

## Requirements
- R1: The address is assembled with the first octet in bits 7:0 and the sixth octet in bits 47:40. A station match, code 1, occurs when the address equals {sa_hi_i[15:0], sa_lo_i[31:0]}, so octet 1 sits in sa_lo_i[7:0] and octet 6 in sa_hi_i[15:8].
- R2: The hash index is the XOR of the address slices [5:0], [11:6], [17:12], [23:18], [29:24], [35:30], [41:36] and [47:42].
- R3: An index from 0 to 31 selects bit index of hash_lo_i. An index from 32 to 63 selects bit (index-32) of hash_hi_i. A set bit gives a hash match, code 2.
- R4: A hash match can only occur while cfg_mc_hash_en_i is 1.
- R5: A hash match can only occur for a group address, meaning address bit 0 (bit 0 of the first octet) is 1.
- R6: The all-ones address is accepted with code 3 regardless of configuration.
- R7: While cfg_copy_all_i is 1, every address is accepted. Code 4 is used when no other test matches.
- R8: Priority from highest to lowest is station (1), broadcast (3), hash (2), copy-all (4).
- R9: result_valid_o is high for exactly one cycle, on the second rising edge after the sixth octet is strobed. When nothing matches, accept_o is 0 and match_o is 0 (code 0). accept_o is 1 exactly when match_o is nonzero.
- R10: An octet strobed with sof_i restarts assembly as octet 1. Octets strobed after the sixth, without sof_i, are ignored and produce no result.
- R11: After reset, result_valid_o and accept_o are 0 and match_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| oct_i | input | 8 | Destination address octet |
| oct_valid_i | input | 1 | Octet strobe |
| sof_i | input | 1 | Marks the strobed octet as octet 1 |
| cfg_copy_all_i | input | 1 | Accept every frame |
| cfg_mc_hash_en_i | input | 1 | Enable multicast hash matching |
| sa_lo_i | input | 32 | Station address octets 1 to 4 |
| sa_hi_i | input | 16 | Station address octets 5 and 6 |
| hash_lo_i | input | 32 | Hash table entries 0 to 31 |
| hash_hi_i | input | 32 | Hash table entries 32 to 63 |
| result_valid_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted |
| match_o | output | 3 | Match code: 0 none, 1 station, 2 hash, 3 broadcast, 4 copy-all |

## Verification
A wrong octet counter or byte lane shows up at the ports on the very next result strobe. A station address that should match is rejected, or a hash lookup lands on a neighbouring bit, and both appear two cycles after the sixth octet. A stuck or skipped counter state also changes when the strobe appears: it comes early or late, repeats on extra octets, or never comes. The bench uses addresses whose fold reaches both hash registers and the outer slices, so a dropped slice or swapped half changes accept_o for at least one vector.

// File: rtl/daf_pkg.sv
package daf_pkg;
  typedef enum logic [2:0] {
    MATCH_NONE    = 3'd0,
    MATCH_STATION = 3'd1,
    MATCH_HASH    = 3'd2,
    MATCH_BCAST   = 3'd3,
    MATCH_COPYALL = 3'd4
  } match_e;
endpackage

// File: rtl/daf_assembler.sv
module daf_assembler #(
  parameter int OCT_W   = 8,
  parameter int NUM_OCT = 6,
  localparam int ADDR_W = OCT_W * NUM_OCT,
  localparam int CNT_W  = $clog2(NUM_OCT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OCT_W-1:0]  oct_i,
  input  logic              oct_valid_i,
  input  logic              sof_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              full_o
);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(NUM_OCT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_OCT - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              full_q;
  logic              take;

  assign take = oct_valid_i && !sof_i && (cnt_q != CNT_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_IDLE;
      full_q <= 1'b0;
    end else begin
      full_q <= take && (cnt_q == CNT_LAST);
      if (oct_valid_i && sof_i) cnt_q <= CNT_W'(1);
      else if (take)            cnt_q <= cnt_q + 1'b1;
    end
  end

  // one write lane per octet position
  for (genvar g = 0; g < NUM_OCT; g++) begin : g_lane
    logic wr;
    if (g == 0) begin : g_first
      assign wr = oct_valid_i && sof_i;
    end else begin : g_rest
      assign wr = take && (cnt_q == CNT_W'(g));
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  addr_q[g*OCT_W +: OCT_W] <= '0;
      else if (wr)  addr_q[g*OCT_W +: OCT_W] <= oct_i;
    end
  end

  assign addr_o = addr_q;
  assign full_o = full_q;
endmodule

// File: rtl/daf_hash.sv
module daf_hash #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6,
  localparam int SLICES = (ADDR_W + IDX_W - 1) / IDX_W,
  localparam int PAD_W  = SLICES * IDX_W,
  localparam int TBL    = 1 << IDX_W,
  localparam int HALF   = TBL / 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF-1:0]   tbl_lo_i,
  input  logic [HALF-1:0]   tbl_hi_i,
  output logic              hit_o
);
  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] acc [SLICES+1];
  logic [TBL-1:0]   tbl;

  assign padded = PAD_W'(addr_i);
  assign acc[0] = '0;

  for (genvar s = 0; s < SLICES; s++) begin : g_fold
    assign acc[s+1] = acc[s] ^ padded[s*IDX_W +: IDX_W];
  end

  assign tbl   = {tbl_hi_i, tbl_lo_i};
  assign hit_o = tbl[acc[SLICES]];
endmodule

// File: rtl/daf_decide.sv
module daf_decide
  import daf_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int SA_LO_W = 32,
  localparam int SA_HI_W = ADDR_W - SA_LO_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               eval_i,
  input  logic               hash_hit_i,
  input  logic [SA_LO_W-1:0] sa_lo_i,
  input  logic [SA_HI_W-1:0] sa_hi_i,
  input  logic               copy_all_i,
  input  logic               hash_en_i,
  output logic               valid_o,
  output logic               accept_o,
  output logic [2:0]         code_o
);
  logic   station, bcast, hash_ok;
  match_e code_d, code_q;
  logic   valid_q, accept_q;

  assign station = (addr_i == {sa_hi_i, sa_lo_i});
  assign bcast   = &addr_i;
  assign hash_ok = hash_en_i && addr_i[0] && hash_hit_i;

  always_comb begin
    if (station)         code_d = MATCH_STATION;
    else if (bcast)      code_d = MATCH_BCAST;
    else if (hash_ok)    code_d = MATCH_HASH;
    else if (copy_all_i) code_d = MATCH_COPYALL;
    else                 code_d = MATCH_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
      code_q   <= MATCH_NONE;
    end else begin
      valid_q  <= eval_i;
      accept_q <= eval_i && (station || bcast || hash_ok || copy_all_i);
      code_q   <= eval_i ? code_d : MATCH_NONE;
    end
  end

  assign valid_o  = valid_q;
  assign accept_o = accept_q;
  assign code_o   = code_q;
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int OCT_W   = 8,
  parameter int NUM_OCT = 6,
  parameter int IDX_W   = 6,
  parameter int SA_LO_W = 32,
  localparam int ADDR_W  = OCT_W * NUM_OCT,
  localparam int SA_HI_W = ADDR_W - SA_LO_W,
  localparam int HALF    = (1 << IDX_W) / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [OCT_W-1:0]   oct_i,
  input  logic               oct_valid_i,
  input  logic               sof_i,
  input  logic               cfg_copy_all_i,
  input  logic               cfg_mc_hash_en_i,
  input  logic [SA_LO_W-1:0] sa_lo_i,
  input  logic [SA_HI_W-1:0] sa_hi_i,
  input  logic [HALF-1:0]    hash_lo_i,
  input  logic [HALF-1:0]    hash_hi_i,
  output logic               result_valid_o,
  output logic               accept_o,
  output logic [2:0]         match_o
);
  logic [ADDR_W-1:0] addr;
  logic              full;
  logic              hit;

  daf_assembler #(.OCT_W(OCT_W), .NUM_OCT(NUM_OCT)) u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni), .oct_i(oct_i), .oct_valid_i(oct_valid_i),
    .sof_i(sof_i), .addr_o(addr), .full_o(full)
  );

  daf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
    .addr_i(addr), .tbl_lo_i(hash_lo_i), .tbl_hi_i(hash_hi_i), .hit_o(hit)
  );

  daf_decide #(.ADDR_W(ADDR_W), .SA_LO_W(SA_LO_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr), .eval_i(full),
    .hash_hit_i(hit), .sa_lo_i(sa_lo_i), .sa_hi_i(sa_hi_i),
    .copy_all_i(cfg_copy_all_i), .hash_en_i(cfg_mc_hash_en_i),
    .valid_o(result_valid_o), .accept_o(accept_o), .code_o(match_o)
  );
endmodule

// File: rtl/daf_checker.sv
module daf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       oct_valid_i,
  input logic       cfg_copy_all_i,
  input logic       cfg_mc_hash_en_i,
  input logic       result_valid_o,
  input logic       accept_o,
  input logic [2:0] match_o
);
  AST_RESULT_AFTER_OCTET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> $past(oct_valid_i, 2)); // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o); // R9
  AST_ACCEPT_MATCHES_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (accept_o == (match_o != 3'd0))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> (!accept_o && match_o == 3'd0)); // R11
  AST_COPY_ALL_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && $past(cfg_copy_all_i)) |-> accept_o); // R7
  AST_HASH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && !$past(cfg_mc_hash_en_i)) |-> (match_o != 3'd2)); // R4
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o <= 3'd4); // R8
endmodule

bind dest_addr_filter daf_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .oct_valid_i(oct_valid_i),
  .cfg_copy_all_i(cfg_copy_all_i), .cfg_mc_hash_en_i(cfg_mc_hash_en_i),
  .result_valid_o(result_valid_o), .accept_o(accept_o), .match_o(match_o)
);

// File: tb/dest_addr_filter_tb_top.sv
module dest_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  oct = '0;
  logic        oct_valid = 1'b0;
  logic        sof = 1'b0;
  logic        copy_all = 1'b0;
  logic        hash_en = 1'b0;
  logic [31:0] sa_lo = 32'h3322_1102;
  logic [15:0] sa_hi = 16'h5544;
  logic [31:0] hlo = '0;
  logic [31:0] hhi = '0;
  logic        res_valid, accept;
  logic [2:0]  match;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dest_addr_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .oct_i(oct), .oct_valid_i(oct_valid), .sof_i(sof),
    .cfg_copy_all_i(copy_all), .cfg_mc_hash_en_i(hash_en),
    .sa_lo_i(sa_lo), .sa_hi_i(sa_hi), .hash_lo_i(hlo), .hash_hi_i(hhi),
    .result_valid_o(res_valid), .accept_o(accept), .match_o(match)
  );

  typedef struct packed {
    logic [47:0] addr;
    logic        cp;
    logic        he;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        acc;
    logic [2:0]  code;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{48'h5544_3322_1102, 1'b0, 1'b0, 32'h0,        32'h0,        1'b1, 3'd1}, // R1 station
    '{48'h0211_2233_4455, 1'b0, 1'b0, 32'h0,        32'h0,        1'b0, 3'd0}, // R1 reversed order
    '{48'h0000_0000_0001, 1'b0, 1'b1, 32'h2,        32'h0,        1'b1, 3'd2}, // R3 idx 1 low
    '{48'h0000_0000_0001, 1'b0, 1'b1, 32'hFFFFFFFD, 32'hFFFFFFFF, 1'b0, 3'd0}, // R3 idx 1 clear
    '{48'h0000_0000_0021, 1'b0, 1'b1, 32'h0,        32'h2,        1'b1, 3'd2}, // R3 idx 33 high
    '{48'h0000_0000_0021, 1'b0, 1'b1, 32'h2,        32'h0,        1'b0, 3'd0}, // R3 idx 33 not low
    '{48'h0400_0000_0001, 1'b0, 1'b1, 32'h1,        32'h0,        1'b1, 3'd2}, // R2 top slice cancels
    '{48'h8000_0000_0001, 1'b0, 1'b1, 32'h0,        32'h2,        1'b1, 3'd2}, // R2 top slice msb
    '{48'h0000_0000_1041, 1'b0, 1'b1, 32'h2,        32'h0,        1'b1, 3'd2}, // R2 slices 0..2
    '{48'h0000_0000_0001, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 3'd0}, // R4 hash off
    '{48'h0000_0000_0002, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 3'd0}, // R5 unicast
    '{48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 32'h0,        32'h0,        1'b1, 3'd3}, // R6 broadcast
    '{48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 3'd3}, // R8 bcast over hash
    '{48'h0000_0000_00AA, 1'b1, 1'b0, 32'h0,        32'h0,        1'b1, 3'd4}, // R7 copy-all
    '{48'h0000_0000_0001, 1'b1, 1'b1, 32'h2,        32'h0,        1'b1, 3'd2}, // R8 hash over copy
    '{48'h5544_3322_1102, 1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 3'd1}, // R8 station first
    '{48'h0000_0000_0001, 1'b1, 1'b1, 32'hFFFFFFFD, 32'h0,        1'b1, 3'd4}  // R7 copy on miss
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic s);
    @(negedge clk);
    oct = b; sof = s; oct_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      oct_valid = 1'b0; sof = 1'b0;
    end
  endtask

  task automatic send(input logic [47:0] a);
    for (int k = 0; k < 6; k++) push(a[k*8 +: 8], k == 0);
  endtask

  // after send: one cycle quiet, then the decision
  task automatic expect_result(input string req, input logic acc, input logic [2:0] code);
    idle(1);
    check({req, " R9 early"}, 48'(res_valid), 48'd0);
    @(negedge clk);
    check({req, " R9 valid"}, 48'(res_valid), 48'd1);
    check({req, " accept"}, 48'(accept), 48'(acc));
    check({req, " code"}, 48'(match), 48'(code));
    @(negedge clk);
    check({req, " R9 pulse"}, 48'(res_valid), 48'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 valid", 48'(res_valid), 48'd0);
    check("R11 accept", 48'(accept), 48'd0);
    check("R11 code", 48'(match), 48'd0);
    rst_n = 1'b1;
    idle(2);

    for (int v = 0; v < NV; v++) begin
      copy_all = VECS[v].cp; hash_en = VECS[v].he;
      hlo = VECS[v].lo; hhi = VECS[v].hi;
      send(VECS[v].addr);
      expect_result($sformatf("vec %0d", v), VECS[v].acc, VECS[v].code);
    end

    // R10: interrupted address, then restart with sof
    copy_all = 1'b1; hash_en = 1'b0; hlo = '0; hhi = '0;
    push(8'h02, 1'b1); push(8'h11, 1'b0); push(8'h22, 1'b0);
    idle(3);
    check("R10 partial no result", 48'(res_valid), 48'd0);
    send(48'h5544_3322_1102);
    expect_result("R10 restart", 1'b1, 3'd1);

    // R10: restart mid-address
    push(8'hAA, 1'b1); push(8'hBB, 1'b0);
    send(48'hFFFF_FFFF_FFFF);
    expect_result("R10 mid restart", 1'b1, 3'd3);

    // R10: octets after the sixth are ignored
    for (int k = 0; k < 8; k++) push(8'hFF, 1'b0);
    idle(1);
    check("R10 extra octets A", 48'(res_valid), 48'd0);
    idle(1);
    check("R10 extra octets B", 48'(res_valid), 48'd0);

    // R9: gaps between octets still assemble
    copy_all = 1'b0;
    push(8'h02, 1'b1); idle(2); push(8'h11, 1'b0); push(8'h22, 1'b0);
    idle(1); push(8'h33, 1'b0); push(8'h44, 1'b0); idle(3);
    check("R9 gap no early", 48'(res_valid), 48'd0);
    push(8'h55, 1'b0);
    expect_result("R9 gapped station R1", 1'b1, 3'd1);

    // R11: reset mid-address clears progress
    push(8'h02, 1'b1); push(8'h11, 1'b0);
    @(negedge clk); oct_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    push(8'h22, 1'b0); push(8'h33, 1'b0); push(8'h44, 1'b0); push(8'h55, 1'b0);
    idle(3);
    check("R11 reset drops partial", 48'(res_valid), 48'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule